// File: doc/BRIEF.md
# External Interrupt Sense and Latch Controller

This block sits between eight general-purpose interrupt pins plus one non-maskable interrupt pin and a parent interrupt controller. Every pin is brought into the clock domain through a two-flop synchronizer. Each of the eight general pins then runs through a detector whose sense mode software selects: low level, falling edge, rising edge or both edges. The NMI pin has its own choice of falling or rising edge.

A detected event sets a sticky request flag. Each flag drives one output wire toward the parent controller. Masking, priority and vectoring happen in that parent.

Software talks to the block over a small 16-bit register bus. The bus has a byte address, write data, a write strobe, a read strobe and combinational read data. A request flag is cleared by writing 0 to its bit. Writing 1 to a bit leaves that flag alone, so a single interrupt can be acknowledged without a read-modify-write race against the others. Software is expected to clear a flag only after it has read that flag back as set.

Top module: `extint_ctrl`

## Requirements
- R1: After reset all request flags and both outputs are 0. Every sense field reads 0 (low level). The NMI edge select reads 0 (falling).
- R2: The registers sit at byte addresses 0 (NMI control), 2 (sense select) and 4 (request). A read of any other address returns 0, and a write to any other address changes no register.
- R3: In the sense-select register, pin n owns bits [2n+1:2n]. Code 0 is low level, 1 is falling edge, 2 is rising edge and 3 is both edges. The field reads back as written.
- R4: Request-register bit n is the flag of pin n. Writing 0 to bit n clears it, and writing 1 to bit n leaves it unchanged.
- R5: In falling-edge mode, a high-to-low pin transition sets the flag; it is visible on the third rising clock edge after the pin changes. A low-to-high transition sets nothing.
- R6: In rising-edge mode, a low-to-high transition sets the flag, and a high-to-low transition sets nothing.
- R7: In both-edge mode, each transition in either direction sets the flag.
- R8: In low-level mode, the flag is set on every cycle while the synchronized pin is low, so a clear has no lasting effect until the pin returns high. Once the pin is high, the flag stays latched until it is cleared.
- R9: NMI control bit 15 reads the synchronized NMI pin level (1 for high) and ignores writes.
- R10: NMI control bit 8 selects the NMI edge (0 falling, 1 rising). Bit 1 is the NMI flag: the selected edge sets it, writing 0 to it clears it, and writing 1 to it has no effect.
- R11: When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R12: Output irq n always equals request flag n, and the NMI output equals the NMI flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_re | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 16 | Combinational read data |
| pin_irq | input | 8 | Asynchronous external interrupt pins |
| pin_nmi | input | 1 | Asynchronous NMI pin |
| irq_out | output | 8 | Per-pin interrupt requests to the parent controller |
| nmi_out | output | 1 | NMI request to the parent controller |

## Verification
The assertions check on every cycle the following behaviours:
- A request or NMI flag only falls in the cycle after a write of 0 to its bit.
- The NMI flag only rises after a change on the synchronized NMI pin.
- A low synchronized pin in low-level mode, or a falling edge in falling-edge mode, always sets the flag on the next cycle.
- The outputs are zero right after reset.

Some behaviours can only be shown by the bench's scenarios:
- The register map and the read-only level bit.
- The three-edge detection latency.
- The absence of events on the opposite edge.
- A selective clear that leaves the other flags untouched.
- A clear overridden by a pin that is still asserted.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int IRQ_CNT  = 8;

    localparam logic [ADDR_W-1:0] OFS_NMI_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_SENSE   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_REQ     = 3'd4;

    localparam int NMI_LVL_BIT  = 15;
    localparam int NMI_EDGE_BIT = 8;
    localparam int NMI_FLAG_BIT = 1;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_NMI_CTL,
        SEL_SENSE,
        SEL_REQ
    } reg_sel_e;

    typedef struct packed {
        logic level_low;
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_NMI_CTL: return SEL_NMI_CTL;
            OFS_SENSE:   return SEL_SENSE;
            OFS_REQ:     return SEL_REQ;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic pin_evt_t classify(input logic cur, input logic prev);
        pin_evt_t ev;
        ev.level_low = ~cur;
        ev.rise      = cur & ~prev;
        ev.fall      = ~cur & prev;
        return ev;
    endfunction

    function automatic logic sense_hit(input sense_e mode, input pin_evt_t ev);
        case (mode)
            SENSE_LOW:  return ev.level_low;
            SENSE_FALL: return ev.fall;
            SENSE_RISE: return ev.rise;
            default:    return ev.rise | ev.fall;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int   WIDTH   = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pin_prev
);
    logic [WIDTH-1:0] meta_q;

    // Two flops of synchronization, then one more stage for the edge history.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= {WIDTH{RST_VAL}};
            pin_sync <= {WIDTH{RST_VAL}};
            pin_prev <= {WIDTH{RST_VAL}};
        end else begin
            meta_q   <= pin_async;
            pin_sync <= meta_q;
            pin_prev <= pin_sync;
        end
    end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_CNT
) (
    input  logic [NUM_IRQ-1:0]      irq_sync,
    input  logic [NUM_IRQ-1:0]      irq_prev,
    input  logic [NUM_IRQ-1:0][1:0] sense_cfg,
    input  logic                    nmi_sync,
    input  logic                    nmi_prev,
    input  logic                    nmi_rise_sel,
    output logic [NUM_IRQ-1:0]      irq_hit,
    output logic                    nmi_hit
);
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_pin
            pin_evt_t ev;
            always_comb begin
                ev         = classify(irq_sync[g], irq_prev[g]);
                irq_hit[g] = sense_hit(sense_e'(sense_cfg[g]), ev);
            end
        end
    endgenerate

    pin_evt_t nmi_ev;
    always_comb begin
        nmi_ev  = classify(nmi_sync, nmi_prev);
        nmi_hit = nmi_rise_sel ? nmi_ev.rise : nmi_ev.fall;
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_CNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    input  logic                    bus_we,
    input  logic                    bus_re,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0]      irq_hit,
    input  logic                    nmi_hit,
    input  logic                    nmi_level,
    output logic [NUM_IRQ-1:0][1:0] sense_cfg,
    output logic                    nmi_rise_sel,
    output logic [NUM_IRQ-1:0]      req_flags,
    output logic                    nmi_flag
);
    localparam int SENSE_W = 2 * NUM_IRQ;

    reg_sel_e           sel;
    logic [NUM_IRQ-1:0] clr_mask;
    logic               nmi_clr;

    always_comb begin
        sel      = decode_addr(bus_addr);
        clr_mask = (bus_we && sel == SEL_REQ) ? ~bus_wdata[NUM_IRQ-1:0] : '0;
        nmi_clr  = bus_we && sel == SEL_NMI_CTL && !bus_wdata[NMI_FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_cfg    <= '0;
            nmi_rise_sel <= 1'b0;
            req_flags    <= '0;
            nmi_flag     <= 1'b0;
        end else begin
            if (bus_we && sel == SEL_SENSE)
                sense_cfg <= bus_wdata[SENSE_W-1:0];
            if (bus_we && sel == SEL_NMI_CTL)
                nmi_rise_sel <= bus_wdata[NMI_EDGE_BIT];
            // A new event overrides a same-cycle clear.
            req_flags <= irq_hit | (req_flags & ~clr_mask);
            nmi_flag  <= nmi_hit | (nmi_flag & ~nmi_clr);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (sel)
                SEL_NMI_CTL: begin
                    bus_rdata[NMI_LVL_BIT]  = nmi_level;
                    bus_rdata[NMI_EDGE_BIT] = nmi_rise_sel;
                    bus_rdata[NMI_FLAG_BIT] = nmi_flag;
                end
                SEL_SENSE: bus_rdata[SENSE_W-1:0] = sense_cfg;
                SEL_REQ:   bus_rdata[NUM_IRQ-1:0] = req_flags;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_CNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_IRQ-1:0] pin_irq,
    input  logic               pin_nmi,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic               nmi_out
);
    logic [NUM_IRQ-1:0]      irq_sync, irq_prev, irq_hit, req_flags;
    logic [NUM_IRQ-1:0][1:0] sense_cfg;
    logic                    nmi_sync, nmi_prev, nmi_hit, nmi_rise_sel, nmi_flag;

    extint_sync #(.WIDTH(NUM_IRQ), .RST_VAL(1'b1)) u_irq_sync (
        .clk(clk), .rst(rst), .pin_async(pin_irq),
        .pin_sync(irq_sync), .pin_prev(irq_prev)
    );

    extint_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_nmi_sync (
        .clk(clk), .rst(rst), .pin_async(pin_nmi),
        .pin_sync(nmi_sync), .pin_prev(nmi_prev)
    );

    extint_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
        .irq_sync(irq_sync), .irq_prev(irq_prev), .sense_cfg(sense_cfg),
        .nmi_sync(nmi_sync), .nmi_prev(nmi_prev), .nmi_rise_sel(nmi_rise_sel),
        .irq_hit(irq_hit), .nmi_hit(nmi_hit)
    );

    extint_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq_hit(irq_hit), .nmi_hit(nmi_hit), .nmi_level(nmi_sync),
        .sense_cfg(sense_cfg), .nmi_rise_sel(nmi_rise_sel),
        .req_flags(req_flags), .nmi_flag(nmi_flag)
    );

    assign irq_out = req_flags;
    assign nmi_out = nmi_flag;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_IRQ = IRQ_CNT
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [REG_W-1:0]        bus_wdata,
    input logic                    bus_we,
    input logic [NUM_IRQ-1:0]      irq_out,
    input logic                    nmi_out,
    input logic [NUM_IRQ-1:0]      irq_sync,
    input logic [NUM_IRQ-1:0]      irq_prev,
    input logic [NUM_IRQ-1:0][1:0] sense_cfg,
    input logic                    nmi_sync,
    input logic                    nmi_prev
);
    AST_RESET_CLEARS_OUTPUTS: assert property (@(posedge clk)
        $past(rst) |-> (irq_out == '0 && !nmi_out)); // R1

    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_chk
            AST_REQ_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $fell(irq_out[g]) |->
                    $past(bus_we && bus_addr == OFS_REQ && !bus_wdata[g])); // R4

            AST_LOW_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
                (sense_cfg[g] == SENSE_LOW && !irq_sync[g]) |=> irq_out[g]); // R8

            AST_FALL_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
                (sense_cfg[g] == SENSE_FALL && irq_prev[g] && !irq_sync[g]) |=> irq_out[g]); // R5
        end
    endgenerate

    AST_NMI_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_out) |->
            $past(bus_we && bus_addr == OFS_NMI_CTL && !bus_wdata[NMI_FLAG_BIT])); // R10

    AST_NMI_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_out) |-> $past(nmi_sync != nmi_prev)); // R10
endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .irq_out(irq_out), .nmi_out(nmi_out),
    .irq_sync(irq_sync), .irq_prev(irq_prev), .sense_cfg(sense_cfg),
    .nmi_sync(nmi_sync), .nmi_prev(nmi_prev)
);

// File: tb/extint_ctrl_bench.sv
module extint_ctrl_bench;
    import extint_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [REG_W-1:0]  bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [REG_W-1:0]  bus_rdata;
    logic [7:0]        pin_irq = 8'hFF;
    logic              pin_nmi = 1'b1;
    logic [7:0]        irq_out;
    logic              nmi_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    extint_ctrl u_extint_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_irq(pin_irq), .pin_nmi(pin_nmi), .irq_out(irq_out), .nmi_out(nmi_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [15:0] d;
        bus_read(OFS_NMI_CTL, d); check("R1 nmi ctl after reset", d, 16'h8000);
        bus_read(OFS_SENSE, d);   check("R1 sense after reset", d, 16'h0000);
        bus_read(OFS_REQ, d);     check("R1 req after reset", d, 16'h0000);
        check("R1 outputs after reset", {7'd0, nmi_out, irq_out}, 16'h0000);
    endtask

    task automatic test_map();
        logic [15:0] d;
        // pin1 falling, pin2 rising, pin3 both; the rest low level
        bus_write(OFS_SENSE, 16'h00E4);
        bus_read(OFS_SENSE, d);   check("R3 sense readback", d, 16'h00E4);
        bus_write(3'd6, 16'hFFFF);
        bus_read(3'd6, d);        check("R2 unmapped read", d, 16'h0000);
        bus_read(OFS_SENSE, d);   check("R2 unmapped write ignored", d, 16'h00E4);
        bus_read(OFS_REQ, d);     check("R2 req untouched", d, 16'h0000);
    endtask

    task automatic test_low_level();
        logic [15:0] d;
        @(negedge clk); pin_irq[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 latency: not yet after two edges", {8'd0, irq_out}, 16'h0000);
        @(negedge clk);
        check("R8 low level sets flag", {8'd0, irq_out}, 16'h0001);
        bus_write(OFS_REQ, 16'hFFFE);
        settle();
        bus_read(OFS_REQ, d);     check("R11 clear loses while pin low", d, 16'h0001);
        @(negedge clk); pin_irq[0] = 1'b1;
        settle();
        bus_read(OFS_REQ, d);     check("R8 flag latched after pin high", d, 16'h0001);
        bus_write(OFS_REQ, 16'hFFFE);
        settle();
        bus_read(OFS_REQ, d);     check("R8 clear after pin high", d, 16'h0000);
    endtask

    task automatic test_edges();
        logic [15:0] d;
        @(negedge clk); pin_irq[2] = 1'b0;
        settle();
        bus_read(OFS_REQ, d);     check("R6 rising mode ignores fall", d, 16'h0000);
        @(negedge clk); pin_irq[1] = 1'b0;
        settle();
        bus_read(OFS_REQ, d);     check("R5 falling mode sets", d, 16'h0002);
        bus_write(OFS_REQ, 16'hFFFD);
        @(negedge clk); pin_irq[1] = 1'b1;
        settle();
        bus_read(OFS_REQ, d);     check("R5 falling mode ignores rise", d, 16'h0000);
        @(negedge clk); pin_irq[2] = 1'b1; pin_irq[1] = 1'b0;
        settle();
        bus_read(OFS_REQ, d);     check("R6 rising mode sets", d, 16'h0006);
        bus_write(OFS_REQ, 16'hFFFF);
        bus_read(OFS_REQ, d);     check("R4 write one keeps flags", d, 16'h0006);
        bus_write(OFS_REQ, 16'hFFFD);
        bus_read(OFS_REQ, d);     check("R4 selective clear", d, 16'h0004);
        check("R12 irq_out follows flags", {8'd0, irq_out}, 16'h0004);
        bus_write(OFS_REQ, 16'h0000);
        @(negedge clk); pin_irq[1] = 1'b1;
        @(negedge clk); pin_irq[3] = 1'b0;
        settle();
        bus_read(OFS_REQ, d);     check("R7 both mode on fall", d, 16'h0008);
        bus_write(OFS_REQ, 16'hFFF7);
        @(negedge clk); pin_irq[3] = 1'b1;
        settle();
        bus_read(OFS_REQ, d);     check("R7 both mode on rise", d, 16'h0008);
        bus_write(OFS_REQ, 16'h0000);
        bus_read(OFS_REQ, d);     check("R4 clear all", d, 16'h0000);
    endtask

    task automatic test_nmi();
        logic [15:0] d;
        @(negedge clk); pin_nmi = 1'b0;
        settle();
        bus_read(OFS_NMI_CTL, d); check("R10 nmi falling sets, R9 level low", d, 16'h0002);
        check("R12 nmi_out follows flag", {15'd0, nmi_out}, 16'h0001);
        bus_write(OFS_NMI_CTL, 16'h8002);
        bus_read(OFS_NMI_CTL, d); check("R9 level bit ignores write", d, 16'h0002);
        bus_write(OFS_NMI_CTL, 16'h0000);
        bus_read(OFS_NMI_CTL, d); check("R10 nmi clear", d, 16'h0000);
        bus_write(OFS_NMI_CTL, 16'h0102);
        @(negedge clk); pin_nmi = 1'b1;
        settle();
        bus_read(OFS_NMI_CTL, d); check("R10 nmi rising sets, R9 level high", d, 16'h8102);
        bus_write(OFS_NMI_CTL, 16'h0100);
        @(negedge clk); pin_nmi = 1'b0;
        settle();
        bus_read(OFS_NMI_CTL, d); check("R10 rising select ignores fall", d, 16'h0100);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_map();
        test_low_level();
        test_edges();
        test_nmi();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule